// File: doc/BRIEF.md
# Arbitrated Local Bus Master

This block carries single-word read and write requests from a host-side memory window out onto an external asynchronous local bus. The host hands over one request at a time: an address, write data, a direction flag and a size flag. The block accepts the request only while it reports itself ready. It then takes ownership of the shared bus through a three-wire handshake. It raises a bus request, waits for the synchronized grant, and holds a grant acknowledge while it uses the bus.

While it owns the bus, the block drives the address, the size line, the read/write line and the chip select. After one cycle of address setup it asserts the data strobe. The cycle ends when one of two things happens first. Either the external device pulls its active-low acknowledge low, or a wait-state counter reaches a limit the host programs. On a timeout the host sees an error flag and zero read data. At the end the strobe is withdrawn first, then the chip select, and then every bus output is released to high impedance. The high-impedance state is modelled here by output-enable lines.

Top module: `lbus_master`

## Requirements
- R1: `host_ready` is high only when no transaction is in progress and the synchronized grant is low. A request presented with `host_req` while ready starts exactly one bus transaction, which has exactly one low pulse of `ds_n_o`.
- R2: After acceptance, `lbus_req` is high and no bus output is enabled until the grant, after two synchronizer stages, is seen. `ctl_oe` is never high while `lbus_gnt` is low.
- R3: `lbus_gack` is high for every cycle in which the block owns the bus (`ctl_oe` high). `lbus_gack` and `lbus_req` fall in the same cycle when the transaction ends.
- R4: While `ctl_oe` is high, the outputs hold the accepted request's values. `la_o` carries the accepted address. `rw_o` is 1 for a read and 0 for a write. `size16_o` is 1 for a 16-bit access and 0 for an 8-bit access. None of these changes during the transaction.
- R5: `ds_n_o` goes low only while `cs_n_o` is low, and only after one cycle with `cs_n_o` low and `ds_n_o` high. `ld_oe` is high only for writes, and while it is high `ld_o` carries the write data.
- R6: When the synchronized `dtack_n_i` is seen low during the strobe, the transaction completes with `host_err` at 0. For a 16-bit read, `host_rdata` is the whole of `ld_i`. For an 8-bit read, `host_rdata` is `ld_i[7:0]` with the upper byte zero. For a write, `host_rdata` is zero.
- R7: If no acknowledge arrives, `ds_n_o` stays low for exactly `wait_limit`+1 cycles. The transaction then completes with `host_err` at 1 and `host_rdata` at zero.
- R8: Whenever the block does not own the bus, `ctl_oe`, `ld_oe`, `lbus_req` and `lbus_gack` are low. This holds after reset, and from the cycle after `host_done` onward.
- R9: `ds_n_o` returns high one cycle before `cs_n_o` returns high. `host_done` is a single-cycle pulse in the cycle where `cs_n_o` is high again and the outputs are still enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request strobe, taken while host_ready is high |
| host_addr | input | ADDR_W | Request address |
| host_wdata | input | DATA_W | Write data |
| host_we | input | 1 | 1 = write, 0 = read |
| host_size16 | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| wait_limit | input | CNT_W | Wait-state limit in clock cycles, sampled at acceptance |
| host_ready | output | 1 | Block can accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | Last transaction ended by timeout |
| host_rdata | output | DATA_W | Read data of last transaction |
| lbus_req | output | 1 | Bus request |
| lbus_gnt | input | 1 | Bus grant (asynchronous) |
| lbus_gack | output | 1 | Bus grant acknowledge |
| la_o | output | ADDR_W | Local address |
| size16_o | output | 1 | Size line, 1 = 16-bit |
| cs_n_o | output | 1 | Chip select, active low |
| rw_o | output | 1 | Read/write line, 1 = read |
| ds_n_o | output | 1 | Data strobe, active low |
| ctl_oe | output | 1 | Enable for address, size, chip select, read/write and strobe |
| ld_o | output | DATA_W | Data bus out |
| ld_oe | output | 1 | Data bus output enable |
| ld_i | input | DATA_W | Data bus in |
| dtack_n_i | input | 1 | Device acknowledge, active low (asynchronous) |

## Verification
The main function is exercised in several ways. Directed accesses separate 16-bit from 8-bit reads, using device data with a non-zero upper byte so that a missing byte mask shows. Writes are exercised through both the acknowledge path and the timeout path. Timeouts with limits of 0 and 5 pin down the exact strobe length and the zero-data, error-flag result. A long grant delay shows that nothing is driven before the grant. A run of seeded random transactions then mixes direction, size, grant latency, acknowledge latency and missing acknowledges, and each result is compared with a value the bench computes from the request.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_ADDR,
    ST_DATA,
    ST_STRB_OFF,
    ST_CS_OFF
  } lbm_state_e;
endpackage

// File: rtl/lbm_sync.sv
module lbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb sr_d = {sr_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_d;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/lbm_wait_timer.sv
module lbm_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign expired = (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: while running and not yet expired, the count advances by one each cycle
  a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !expired && $past(run)) |-> (cnt_q == $past(cnt_q) + 1'b1) || $past(expired));

  // R7: a new run always starts from zero
  a_r7_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/lbus_master.sv
module lbus_master
  import lbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_we,
  input  logic              host_size16,
  input  logic [CNT_W-1:0]  wait_limit,
  output logic              host_ready,
  output logic              host_done,
  output logic              host_err,
  output logic [DATA_W-1:0] host_rdata,
  output logic              lbus_req,
  input  logic              lbus_gnt,
  output logic              lbus_gack,
  output logic [ADDR_W-1:0] la_o,
  output logic              size16_o,
  output logic              cs_n_o,
  output logic              rw_o,
  output logic              ds_n_o,
  output logic              ctl_oe,
  output logic [DATA_W-1:0] ld_o,
  output logic              ld_oe,
  input  logic [DATA_W-1:0] ld_i,
  input  logic              dtack_n_i
);
  localparam int BYTE_W = 8;

  lbm_state_e state_q, state_d;

  logic              gnt_s;
  logic              dtack_n_s;
  logic              expired;
  logic              accept;
  logic              finish;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic              size16_q;
  logic [CNT_W-1:0]  limit_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;

  lbm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_gnt_sync (
    .clk(clk), .rst_n(rst_n), .d(lbus_gnt), .q(gnt_s));

  lbm_sync #(.STAGES(2), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(dtack_n_i), .q(dtack_n_s));

  lbm_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(state_q == ST_DATA),
    .limit(limit_q), .expired(expired));

  assign host_ready = (state_q == ST_IDLE) && !gnt_s;
  assign accept     = host_ready && host_req;
  assign finish     = (state_q == ST_DATA) && (!dtack_n_s || expired);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (accept) state_d = ST_ARB;
      ST_ARB:      if (gnt_s)  state_d = ST_ADDR;
      ST_ADDR:     state_d = ST_DATA;
      ST_DATA:     if (finish) state_d = ST_STRB_OFF;
      ST_STRB_OFF: state_d = ST_CS_OFF;
      ST_CS_OFF:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    err_d   = err_q;
    if (finish) begin
      if (!dtack_n_s) begin
        err_d = 1'b0;
        if (we_q)          rdata_d = '0;
        else if (size16_q) rdata_d = ld_i;
        else               rdata_d = {{(DATA_W-BYTE_W){1'b0}}, ld_i[BYTE_W-1:0]};
      end else begin
        err_d   = 1'b1;
        rdata_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      size16_q <= 1'b0;
      limit_q  <= '0;
    end else if (accept) begin
      addr_q   <= host_addr;
      wdata_q  <= host_wdata;
      we_q     <= host_we;
      size16_q <= host_size16;
      limit_q  <= wait_limit;
    end
  end

  assign lbus_req   = (state_q != ST_IDLE);
  assign lbus_gack  = (state_q != ST_IDLE) && (state_q != ST_ARB);
  assign ctl_oe     = lbus_gack;
  assign cs_n_o     = !((state_q == ST_ADDR) || (state_q == ST_DATA) || (state_q == ST_STRB_OFF));
  assign ds_n_o     = (state_q != ST_DATA);
  assign rw_o       = !we_q;
  assign size16_o   = size16_q;
  assign la_o       = addr_q;
  assign ld_o       = wdata_q;
  assign ld_oe      = ctl_oe && we_q;
  assign host_done  = (state_q == ST_CS_OFF);
  assign host_err   = err_q;
  assign host_rdata = rdata_q;

  // R2: ownership starts only with the synchronized grant present
  a_r2_own_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lbus_gack) |-> $past(gnt_s));

  // R3: acknowledge and request are released together
  a_r3_release_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lbus_gack) |-> $fell(lbus_req));

  // R4: address stays put while the bus is owned
  a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_oe && $past(ctl_oe)) |-> $stable(la_o) && $stable(rw_o) && $stable(size16_o));

  // R5: strobe only inside chip select, after a setup cycle
  a_r5_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n_o |-> !cs_n_o);
  a_r5_setup_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n_o) |-> $past(!cs_n_o));

  // R8: nothing enabled without the grant acknowledge
  a_r8_float_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lbus_gack |-> !ctl_oe && !ld_oe);

  // R9: strobe withdrawn a cycle before chip select
  a_r9_strobe_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> $past(ds_n_o));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
endmodule

// File: tb/lbus_master_tb_top.sv
`timescale 1ns/1ps
module lbus_master_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic              host_req, host_we, host_size16;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic [CNT_W-1:0]  wait_limit;
  logic              host_ready, host_done, host_err;
  logic [DATA_W-1:0] host_rdata;
  logic              lbus_req, lbus_gnt, lbus_gack;
  logic [ADDR_W-1:0] la_o;
  logic              size16_o, cs_n_o, rw_o, ds_n_o, ctl_oe, ld_oe;
  logic [DATA_W-1:0] ld_o, ld_i;
  logic              dtack_n_i;

  lbus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_we(host_we), .host_size16(host_size16),
    .wait_limit(wait_limit), .host_ready(host_ready), .host_done(host_done),
    .host_err(host_err), .host_rdata(host_rdata), .lbus_req(lbus_req),
    .lbus_gnt(lbus_gnt), .lbus_gack(lbus_gack), .la_o(la_o), .size16_o(size16_o),
    .cs_n_o(cs_n_o), .rw_o(rw_o), .ds_n_o(ds_n_o), .ctl_oe(ctl_oe), .ld_o(ld_o),
    .ld_oe(ld_oe), .ld_i(ld_i), .dtack_n_i(dtack_n_i));

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int              gnt_delay;
  bit              dev_ack_en;
  int              dev_delay;
  logic [DATA_W-1:0] dev_rdata;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_rdata(input bit we, input bit s16,
                                                  input bit acked, input logic [DATA_W-1:0] d);
    if (!acked || we) return '0;
    if (s16) return d;
    return {8'h00, d[7:0]};
  endfunction

  // bus arbiter model
  initial begin
    lbus_gnt = 1'b0;
    forever begin
      @(negedge clk);
      if (lbus_req && !lbus_gnt) begin
        repeat (gnt_delay) @(negedge clk);
        lbus_gnt = 1'b1;
      end else if (!lbus_req && lbus_gnt) begin
        lbus_gnt = 1'b0;
      end
    end
  end

  // external device model
  initial begin
    dtack_n_i = 1'b1;
    ld_i = '0;
    forever begin
      @(negedge clk);
      if (ctl_oe && !ds_n_o && dev_ack_en) begin
        repeat (dev_delay) @(negedge clk);
        ld_i = dev_rdata;
        dtack_n_i = 1'b0;
        while (!ds_n_o) @(negedge clk);
        dtack_n_i = 1'b1;
        ld_i = '0;
      end
    end
  end

  // R2: never enabled without grant; R3: gack whenever owned
  always @(negedge clk) begin
    if (rst_n && ctl_oe && !lbus_gnt)
      check(1'b0, "R2", "ctl_oe without grant", ctl_oe, 0);
    if (rst_n && ctl_oe && !lbus_gack)
      check(1'b0, "R3", "owned without gack", lbus_gack, 1);
  end

  task automatic run_txn(input bit we, input bit s16, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input int lim, input bit ack,
                         input int ackdly, input int gdly, input logic [DATA_W-1:0] rd);
    int ds_low = 0, ds_falls = 0, setup_bad = 0, hold_bad = 0, order_bad = 0, busy_bad = 0;
    int guard = 0;
    logic prev_ds = 1'b1, prev_cs = 1'b1;
    gnt_delay = gdly; dev_ack_en = ack; dev_delay = ackdly; dev_rdata = rd;
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_we = we; host_size16 = s16; host_addr = a;
    host_wdata = wd; wait_limit = CNT_W'(lim);
    @(negedge clk);
    host_req = 1'b0;
    host_addr = ~a; host_wdata = ~wd; host_we = ~we; wait_limit = '0;
    while (!host_done && guard < 2000) begin
      guard++;
      if (host_ready) busy_bad++;
      if (!ds_n_o) ds_low++;
      if (prev_ds && !ds_n_o) begin
        ds_falls++;
        if (prev_cs) setup_bad++;
      end
      if (!prev_cs && cs_n_o && !prev_ds) order_bad++;
      if (ctl_oe) begin
        if (la_o !== a || rw_o !== !we || size16_o !== s16 || ld_oe !== we) hold_bad++;
        if (we && ld_o !== wd) hold_bad++;
      end else if (ld_oe) hold_bad++;
      prev_ds = ds_n_o; prev_cs = cs_n_o;
      @(negedge clk);
    end
    // now in the done cycle
    check(busy_bad == 0, "R1", "ready during transaction", busy_bad, 0);
    check(ds_falls == 1, "R1", "strobe pulses", ds_falls, 1);
    check(setup_bad == 0, "R5", "strobe without setup cycle", setup_bad, 0);
    check(hold_bad == 0, "R4", "bus values not held", hold_bad, 0);
    check(cs_n_o && ds_n_o && ctl_oe && !prev_cs && prev_ds && order_bad == 0,
          "R9", "strobe/cs release order", {cs_n_o, ds_n_o, ctl_oe, prev_cs, prev_ds}, 5'b11101);
    check(host_err == !ack, ack ? "R6" : "R7", "error flag", host_err, !ack);
    check(host_rdata == exp_rdata(we, s16, ack, rd), ack ? "R6" : "R7", "read data",
          host_rdata, exp_rdata(we, s16, ack, rd));
    if (!ack) check(ds_low == lim + 1, "R7", "strobe length", ds_low, lim + 1);
    @(negedge clk);
    check(!ctl_oe && !ld_oe && !lbus_req && !lbus_gack && !host_done, "R8",
          "released after done", {ctl_oe, ld_oe, lbus_req, lbus_gack, host_done}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    gnt_delay = 0; dev_ack_en = 0; dev_delay = 0; dev_rdata = '0;
    host_req = 0; host_we = 0; host_size16 = 0; host_addr = '0;
    host_wdata = '0; wait_limit = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(!lbus_req && !lbus_gack && !ctl_oe && !ld_oe && !host_done && cs_n_o && ds_n_o,
          "R8", "reset state outputs", {lbus_req, lbus_gack, ctl_oe, ld_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(host_ready, "R1", "ready after reset", host_ready, 1);
    // directed corners
    run_txn(1, 1, 16'h1234, 16'hBEEF, 20, 1, 1, 1, 16'hFFFF);   // write acked
    run_txn(0, 1, 16'h00A0, 16'h0000, 20, 1, 2, 0, 16'hC3A5);   // 16-bit read
    run_txn(0, 0, 16'h00A1, 16'h0000, 20, 1, 0, 2, 16'hC3A5);   // 8-bit read masks upper byte
    run_txn(0, 1, 16'h7777, 16'h0000, 0, 0, 0, 1, 16'h5555);    // timeout at limit 0
    run_txn(0, 0, 16'h8001, 16'h0000, 5, 0, 0, 0, 16'h5555);    // timeout at limit 5
    run_txn(1, 0, 16'hFFFF, 16'h00AA, 3, 0, 0, 1, 16'h0000);    // write timeout
    run_txn(1, 1, 16'h0F0F, 16'h1357, 20, 1, 3, 6, 16'h0000);   // long grant delay
    // seeded random mix
    for (int i = 0; i < 30; i++) begin
      bit ack_r;
      int lim_r;
      ack_r = ($urandom % 4) != 0;
      lim_r = ack_r ? 12 + int'($urandom % 19) : int'($urandom % 16);
      run_txn(bit'($urandom % 2), bit'($urandom % 2), ADDR_W'($urandom),
              DATA_W'($urandom), lim_r, ack_r, int'($urandom % 5),
              int'($urandom % 5), DATA_W'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule